// File: doc/BRIEF.md
# Chip-select pin routing crossbar

This block steers the active-low chip-select lines of several serial controller instances onto a shared bank of external pins. Every source line (two per controller, carrying either the SPI selects or the USART flow-control pair) owns one routing mask register. A cleared bit in a source's mask connects that source to the matching pin. Software rewrites a mask between transfers so that one select line can reach different devices on different pins at different times.

Registers sit on a simple word-addressed bus. Writes take effect on the next clock edge, and reads are combinational. Every pin is driven low whenever any source mapped to it is asserted, and it idles high when nothing is mapped to it. When two or more sources share a pin, the block records a sticky conflict flag that software clears through a write-one-to-clear status register.

Top module: `cs_xbar`

## Requirements
- R1: After reset every mask register reads 0x1FFFFF, the status register reads 0, conflict_o is 0 and every pin output is high.
- R2: The mask register for controller k, select line c (source index s = 2*k + c) is at byte offset 8*k + 4*c. A write stores bits [20:0] of the write data at the next rising clock edge. A read returns the stored mask in bits [20:0] and zero in bits [31:21].
- R3: A pin whose mask bit is cleared for exactly one source follows that source's chip-select input, with no clock delay.
- R4: A source whose mask has several bits cleared drives all of those pins at once.
- R5: A pin that no source has mapped stays high, whatever the chip-select inputs are.
- R6: A pin mapped to several sources is the logical AND of their active-low chip-selects.
- R7: conflict_o (status bit 0 at offset 0x28) sets one clock after any pin has two or more mapped sources. It then stays set after the collision has been removed.
- R8: A write to offset 0x28 with data bit 0 set clears the conflict flag, unless a collision is still present at that edge, in which case the flag stays set. A write there with bit 0 clear has no effect.
- R9: A write to an offset that is not word-aligned or lies above 0x28 changes no register, and a read from such an offset returns zero.
- R10: Rewriting a mask moves a source from its old pin to its new pin, and the old pin returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data for bus_addr_i |
| cs_n_i | input | N_CTRL*N_CS | Active-low chip-selects, source s = 2*k + c |
| pin_n_o | output | N_PIN | Shared pin drive, active low |
| conflict_o | output | 1 | Sticky pin-collision flag |

## Verification
The bench targets the following corner cases:
- Write data with bits set above bit 20. A design that stores the full word reads back a nonzero upper field.
- A write held on the bus but not yet clocked. A design with a combinational write path reads back the new value too early.
- Unaligned and out-of-range writes. A design that decodes only the upper address bits corrupts a neighbouring mask.
- Several sources on one pin. A design that ORs the selects, or that lets the last source win, drives the wrong level on that pin.
- The conflict flag's one-cycle latency, its stickiness, and the clear request that arrives while a collision is still present. A design that gives the clear priority drops a live collision.

// File: rtl/cs_xbar_pkg.sv
package cs_xbar_pkg;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_MASK = 2'd1,
    REG_STAT = 2'd2
  } reg_kind_e;

  // Word-aligned decode: masks occupy words 0..n_src-1, status is word n_src.
  function automatic reg_kind_e decode_addr(input logic [15:0] addr, input int unsigned n_src);
    if (addr[1:0] != 2'b00)                 return REG_NONE;
    if (int'(addr[15:2]) < int'(n_src))     return REG_MASK;
    if (int'(addr[15:2]) == int'(n_src))    return REG_STAT;
    return REG_NONE;
  endfunction

endpackage

// File: rtl/cs_xbar_regs.sv
module cs_xbar_regs
  import cs_xbar_pkg::*;
#(
  parameter int N_SRC  = 10,
  parameter int N_PIN  = 21,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        wr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic                        conflict_i,
  output logic [N_SRC-1:0][N_PIN-1:0] mask_o,
  output logic                        clr_o,
  output logic [DATA_W-1:0]           rdata_o
);

  localparam int IDX_W = ADDR_W - 2;

  reg_kind_e        kind;
  logic [IDX_W-1:0] idx;

  assign kind = decode_addr(16'(addr_i), N_SRC);
  assign idx  = addr_i[ADDR_W-1:2];

  for (genvar s = 0; s < N_SRC; s++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mask_o[s] <= '1;
      else if (wr_i && kind == REG_MASK && idx == IDX_W'(s))
        mask_o[s] <= wdata_i[N_PIN-1:0];
    end
  end

  assign clr_o = wr_i && (kind == REG_STAT) && wdata_i[0];

  always_comb begin
    rdata_o = '0;
    case (kind)
      REG_MASK: begin
        for (int s = 0; s < N_SRC; s++)
          if (idx == IDX_W'(s)) rdata_o[N_PIN-1:0] = mask_o[s];
      end
      REG_STAT: rdata_o[0] = conflict_i;
      default:  rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/cs_xbar_route.sv
module cs_xbar_route #(
  parameter int N_SRC = 10,
  parameter int N_PIN = 21
) (
  input  logic [N_SRC-1:0][N_PIN-1:0] mask_i,
  input  logic [N_SRC-1:0]            cs_n_i,
  output logic [N_PIN-1:0]            pin_n_o
);

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    logic [N_SRC-1:0] unmapped;
    always_comb
      for (int s = 0; s < N_SRC; s++) unmapped[s] = mask_i[s][p];
    // Unmapped sources are forced high so they drop out of the AND.
    assign pin_n_o[p] = &(cs_n_i | unmapped);
  end

endmodule

// File: rtl/cs_xbar_conflict.sv
module cs_xbar_conflict #(
  parameter int N_SRC = 10,
  parameter int N_PIN = 21
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_SRC-1:0][N_PIN-1:0] mask_i,
  input  logic                        clr_i,
  output logic                        conflict_o
);

  logic [N_PIN-1:0] multi;

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    logic [N_SRC-1:0] sel;
    always_comb
      for (int s = 0; s < N_SRC; s++) sel[s] = ~mask_i[s][p];
    // More than one bit set: clearing the lowest set bit leaves something.
    assign multi[p] = |(sel & (sel - 1'b1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         conflict_o <= 1'b0;
    else if (|multi)     conflict_o <= 1'b1;
    else if (clr_i)      conflict_o <= 1'b0;
  end

endmodule

// File: rtl/cs_xbar.sv
module cs_xbar #(
  parameter int N_CTRL = 5,
  parameter int N_CS   = 2,
  parameter int N_PIN  = 21,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic                   bus_wr_i,
  input  logic [DATA_W-1:0]      bus_wdata_i,
  output logic [DATA_W-1:0]      bus_rdata_o,
  input  logic [N_CTRL*N_CS-1:0] cs_n_i,
  output logic [N_PIN-1:0]       pin_n_o,
  output logic                   conflict_o
);

  localparam int N_SRC = N_CTRL * N_CS;

  logic [N_SRC-1:0][N_PIN-1:0] mask_q;
  logic                        clr;

  cs_xbar_regs #(
    .N_SRC(N_SRC), .N_PIN(N_PIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (bus_addr_i),
    .wr_i       (bus_wr_i),
    .wdata_i    (bus_wdata_i),
    .conflict_i (conflict_o),
    .mask_o     (mask_q),
    .clr_o      (clr),
    .rdata_o    (bus_rdata_o)
  );

  cs_xbar_route #(.N_SRC(N_SRC), .N_PIN(N_PIN)) u_route (
    .mask_i  (mask_q),
    .cs_n_i  (cs_n_i),
    .pin_n_o (pin_n_o)
  );

  cs_xbar_conflict #(.N_SRC(N_SRC), .N_PIN(N_PIN)) u_conflict (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mask_i     (mask_q),
    .clr_i      (clr),
    .conflict_o (conflict_o)
  );

endmodule

// File: rtl/cs_xbar_chk.sv
module cs_xbar_chk #(
  parameter int N_SRC  = 10,
  parameter int N_PIN  = 21,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [ADDR_W-1:0]           bus_addr_i,
  input logic                        bus_wr_i,
  input logic [DATA_W-1:0]           bus_wdata_i,
  input logic [DATA_W-1:0]           bus_rdata_o,
  input logic [N_PIN-1:0]            pin_n_o,
  input logic                        conflict_o,
  input logic [N_SRC-1:0][N_PIN-1:0] mask_q
);

  logic [N_PIN-1:0] shared;
  logic             bad_addr;
  logic             clr_req;

  assign bad_addr = (bus_addr_i[1:0] != 2'b00) ||
                    (int'(bus_addr_i[ADDR_W-1:2]) > N_SRC);
  assign clr_req  = bus_wr_i && (int'(bus_addr_i) == 4 * N_SRC) && bus_wdata_i[0];

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    logic [N_SRC-1:0] used;
    always_comb
      for (int s = 0; s < N_SRC; s++) used[s] = ~mask_q[s][p];
    assign shared[p] = ($countones(used) >= 2);

    // R5
    idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (used == '0) |-> pin_n_o[p]);
  end

  // R7
  conflict_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|shared) |=> conflict_o);

  // R7
  conflict_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conflict_o && !clr_req) |=> conflict_o);

  // R8
  conflict_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req && !(|shared)) |=> !conflict_o);

  // R9
  bad_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bad_addr) |=> $stable(mask_q));

  // R9
  bad_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_addr |-> (bus_rdata_o == '0));

endmodule

bind cs_xbar cs_xbar_chk #(
  .N_SRC(N_CTRL * N_CS), .N_PIN(N_PIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .pin_n_o     (pin_n_o),
  .conflict_o  (conflict_o),
  .mask_q      (mask_q)
);

// File: tb/cs_xbar_tb_top.sv
module cs_xbar_tb_top;

  localparam int N_SRC = 10;
  localparam int N_PIN = 21;
  localparam logic [N_PIN-1:0] ALL1 = '1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [N_SRC-1:0] cs_n_i = '1;
  logic [N_PIN-1:0] pin_n_o;
  logic        conflict_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  cs_xbar dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .cs_n_i(cs_n_i),
    .pin_n_o(pin_n_o), .conflict_o(conflict_o)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int N_VEC = 8;
  localparam vec_t VEC [N_VEC] = '{
    '{8'h18, 32'h001F_FDFF, 32'h001F_FDFF},  // R2 ctrl3 cs0 -> pin 9
    '{8'h1C, 32'hFFFF_FF7F, 32'h001F_FF7F},  // R2 upper bits dropped
    '{8'h20, 32'h001F_FFEF, 32'h001F_FFEF},  // R2 ctrl4 cs0 -> pin 4
    '{8'h24, 32'h001F_FFBF, 32'h001F_FFBF},  // R2 ctrl4 cs1 -> pin 6
    '{8'h04, 32'hAAAA_AAAA, 32'h000A_AAAA},  // R2 ctrl0 cs1
    '{8'h00, 32'h0000_0000, 32'h0000_0000},  // R2 all pins cleared
    '{8'h2C, 32'h0001_2345, 32'h0000_0000},  // R9 beyond status
    '{8'h19, 32'h0000_0000, 32'h0000_0000}   // R9 unaligned
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #0.5;
    d = bus_rdata_o;
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  initial begin : watchdog
    #400000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    logic [N_PIN-1:0] e;
    do_reset();

    // R1 reset state
    for (int s = 0; s < N_SRC; s++) begin
      rd(8'(4 * s), r);
      chk(r == 32'h001F_FFFF, "R1 mask reset", r, 32'h001F_FFFF);
    end
    rd(8'h28, r);
    chk(r == 0, "R1 status reset", r, 0);
    chk(pin_n_o == ALL1 && conflict_o == 1'b0, "R1 pins/conflict", {10'b0, conflict_o, pin_n_o}, {11'b0, ALL1});

    // R2/R9 table walk
    for (int i = 0; i < N_VEC; i++) begin
      wr(VEC[i].addr, VEC[i].wdata);
      rd(VEC[i].addr, r);
      chk(r == VEC[i].exp, "R2/R9 table", r, VEC[i].exp);
    end
    rd(8'h18, r);
    chk(r == 32'h001F_FDFF, "R9 unaligned write left 0x18", r, 32'h001F_FDFF);

    do_reset();

    // R2 write not visible before the clock edge
    @(negedge clk_i);
    bus_addr_i = 8'h18; bus_wdata_i = 32'h001F_FDFF; bus_wr_i = 1'b1;
    #0.5;
    chk(bus_rdata_o == 32'h001F_FFFF, "R2 pre-edge old value", bus_rdata_o, 32'h001F_FFFF);
    @(negedge clk_i);
    bus_wr_i = 1'b0;
    rd(8'h18, r);
    chk(r == 32'h001F_FDFF, "R2 post-edge new value", r, 32'h001F_FDFF);

    // R3 source 6 -> pin 9
    cs_n_i = '1; #0.5;
    chk(pin_n_o == ALL1, "R3 idle", pin_n_o, ALL1);
    cs_n_i[6] = 1'b0; #0.5;
    e = ALL1; e[9] = 1'b0;
    chk(pin_n_o == e, "R3 pin9 follows src6", pin_n_o, e);

    // R5 unmapped source asserted leaves pins high
    cs_n_i = '1; cs_n_i[0] = 1'b0; #0.5;
    chk(pin_n_o == ALL1, "R5 unmapped source", pin_n_o, ALL1);

    // R4 fan-out of source 6 to pins 2 and 3
    wr(8'h18, 32'h001F_FFF3);
    cs_n_i = '1; cs_n_i[6] = 1'b0; #0.5;
    e = ALL1; e[2] = 1'b0; e[3] = 1'b0;
    chk(pin_n_o == e, "R4 fan-out", pin_n_o, e);

    // R10 move source 6 to pin 7
    wr(8'h18, 32'h001F_FF7F);
    #0.5;
    e = ALL1; e[7] = 1'b0;
    chk(pin_n_o == e, "R10 remap", pin_n_o, e);
    chk(conflict_o == 1'b0, "R7 no conflict yet", conflict_o, 0);

    // R6/R7 source 8 also onto pin 7
    wr(8'h20, 32'h001F_FF7F);
    #0.5;
    chk(conflict_o == 1'b0, "R7 latency one clock", conflict_o, 0);
    tick(); #0.5;
    chk(conflict_o == 1'b1, "R7 set", conflict_o, 1);
    rd(8'h28, r);
    chk(r == 32'h1, "R7 status read", r, 1);
    cs_n_i = '1; cs_n_i[8] = 1'b0; #0.5;
    chk(pin_n_o == e, "R6 src8 alone", pin_n_o, e);
    cs_n_i = '1; #0.5;
    chk(pin_n_o == ALL1, "R6 both high", pin_n_o, ALL1);

    // R8 clear with bit0=0 and with live collision
    wr(8'h28, 32'hFFFF_FFFE); #0.5;
    chk(conflict_o == 1'b1, "R8 bit0 clear no effect", conflict_o, 1);
    wr(8'h28, 32'h1); #0.5;
    chk(conflict_o == 1'b1, "R8 live collision holds", conflict_o, 1);

    // R7 sticky after collision removed
    wr(8'h20, 32'h001F_FFEF);
    tick(); tick(); #0.5;
    chk(conflict_o == 1'b1, "R7 sticky", conflict_o, 1);

    // R8 clear
    wr(8'h28, 32'h1);
    rd(8'h28, r);
    chk(r == 32'h0, "R8 cleared", r, 0);

    // R9 out-of-range write leaves masks
    wr(8'h40, 32'h0);
    rd(8'h40, r);
    chk(r == 0, "R9 read zero", r, 0);
    rd(8'h20, r);
    chk(r == 32'h001F_FFEF, "R9 mask untouched", r, 32'h001F_FFEF);
    tick(); #0.5;
    chk(conflict_o == 1'b0, "R9 no spurious conflict", conflict_o, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule